// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Slave

This block is the device side of a serial flash read port. A host selects it with an active-low select, toggles a serial clock and exchanges data on up to four lanes. The first eight clocks of every selection carry an opcode on lane 0. The opcode chooses the width (one, two or four lanes) of the address, mode and data phases, and also how many dummy clocks come before the data. Read data comes from a small on-chip pattern array. A status byte holds a quad-enable flag, and all four-lane commands are refused unless that flag is set.

The serial pins are brought into a fast system clock through synchronizers, and the logic acts on the detected clock edges. Input lanes are captured on rising serial edges. Output lanes change on falling serial edges. The serial clock may rest either low or high while the select line changes. Releasing the select at any point ends the command and floats every lane.

Top module: `mlane_flash_rd`

## Requirements
- R1: After reset, and whenever select is high, all four lane enables (io_oe) are 0. A select rise at any point aborts the command, and the next selection starts again with an opcode.
- R2: The opcode is shifted in MSB first on lane 0 at rising serial edges. The 24-bit address follows MSB first. Only its low log2(DEPTH) bits index the array.
- R3: Opcode 03h reads with no dummy clocks and opcode 0Bh reads after 8 dummy clocks. Both take the address on lane 0 and return data MSB first on lane 1 only (io_oe = 0010b). The first data bit appears after the first falling edge that follows the last address or dummy clock.
- R4: Opcode 3Bh takes the address on lane 0 and waits 8 dummy clocks. It then returns two bits per clock on lanes 1:0 (io_oe = 0011b), with the higher bit on lane 1.
- R5: Opcode BBh takes the address and then an 8-bit mode byte on lanes 1:0, with the higher bit on lane 1. It has no dummy clocks and returns data on lanes 1:0.
- R6: Opcode 6Bh takes the address on lane 0 and waits 8 dummy clocks. It then returns a nibble per clock on all four lanes (io_oe = 1111b), with lane 3 carrying the highest bit.
- R7: Opcodes EBh, E7h and E3h take the address and a mode byte on four lanes (lane 3 highest). They then wait 4, 2 and 0 dummy clocks respectively, and return data on four lanes.
- R8: While the quad-enable flag is 0, the opcodes 6Bh, EBh, E7h and E3h are ignored, and no lane is driven until select rises.
- R9: Opcode 31h followed by one byte on lane 0 sets the quad-enable flag from bit 1 of that byte. Opcode 35h returns the status byte on lane 1, with the flag at bit 1 and all other bits 0. The flag resets to 0.
- R10: Array byte a holds (a*37+11) mod 256, with DEPTH = 256. Each further data byte reads the next address, and the address wraps from DEPTH-1 to 0.
- R11: A command gives identical results whether the serial clock rests low (mode 0) or high (mode 3) at the select edges.
- R12: Any opcode not listed above is ignored, and no lane is driven until select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| io_in | input | 4 | Lane inputs; lane 0 carries opcode and single-lane input |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Per-lane output enable, 1 = driven |

## Verification
The two events that can land on the same system cycle are a select release and a falling serial edge that would drive the next data bits, because both pins pass through the same synchronizer depth. The bench provokes this by ending a selection halfway through a data byte, where the final falling edge and the select rise lie only a few system cycles apart. The bench then checks two things. All enables must read zero once the select has settled high. The following command must read its own address from a fresh opcode, with no leftover shift state.

// File: rtl/mlane_flash_pkg.sv
package mlane_flash_pkg;

   typedef enum logic [2:0] {
      PH_OPC, PH_ADR, PH_MOD, PH_DUM, PH_DAT, PH_WST, PH_IGN
   } phase_e;

   typedef enum logic [1:0] {LN1 = 2'd0, LN2 = 2'd1, LN4 = 2'd2} lanes_e;

   typedef struct packed {
      logic       ok;
      logic       quad;
      logic       has_adr;
      logic       has_mode;
      logic [3:0] dummy;
      lanes_e     adr_w;
      lanes_e     dat_w;
      logic       src_stat;
      logic       wr_stat;
   } cmd_desc_t;

   localparam logic [7:0] OP_RD1   = 8'h03;
   localparam logic [7:0] OP_FRD1  = 8'h0B;
   localparam logic [7:0] OP_FRD2O = 8'h3B;
   localparam logic [7:0] OP_FRD2A = 8'hBB;
   localparam logic [7:0] OP_FRD4O = 8'h6B;
   localparam logic [7:0] OP_FRD4A = 8'hEB;
   localparam logic [7:0] OP_WRD4  = 8'hE7;
   localparam logic [7:0] OP_OWRD4 = 8'hE3;
   localparam logic [7:0] OP_STW   = 8'h31;
   localparam logic [7:0] OP_STR   = 8'h35;

   function automatic logic [2:0] lane_bits(lanes_e w);
      case (w)
         LN2:     return 3'd2;
         LN4:     return 3'd4;
         default: return 3'd1;
      endcase
   endfunction

   function automatic logic [3:0] lane_mask(lanes_e w);
      case (w)
         LN2:     return 4'b0011;
         LN4:     return 4'b1111;
         default: return 4'b0010;
      endcase
   endfunction

   // place the top bits of a byte onto the lanes for the chosen width
   function automatic logic [3:0] lane_put(logic [7:0] b, lanes_e w);
      case (w)
         LN2:     return {2'b00, b[7:6]};
         LN4:     return b[7:4];
         default: return {2'b00, b[7], 1'b0};
      endcase
   endfunction

endpackage

// File: rtl/mlane_flash_sync.sv
module mlane_flash_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck,
   input  logic       cs_n,
   input  logic [3:0] io,
   output logic       cs_n_s,
   output logic [3:0] io_s,
   output logic       sck_rise,
   output logic       sck_fall
);
   localparam int unsigned W = 6;
   localparam logic [W-1:0] RST_VAL = {1'b1, 1'b0, 4'b0000};

   logic [W-1:0] pipe [STAGES];
   logic         sck_prev;

   if (STAGES < 2) begin : g_bad_stages
      $error("mlane_flash_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pipe[i] <= RST_VAL;
         else if (i == 0) pipe[i] <= {cs_n, sck, io};
         else             pipe[i] <= pipe[(i == 0) ? 0 : i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= pipe[STAGES-1][4];
   end

   assign cs_n_s   = pipe[STAGES-1][5];
   assign io_s     = pipe[STAGES-1][3:0];
   assign sck_rise =  pipe[STAGES-1][4] & ~sck_prev;
   assign sck_fall = ~pipe[STAGES-1][4] &  sck_prev;
endmodule

// File: rtl/mlane_flash_decode.sv
module mlane_flash_decode
   import mlane_flash_pkg::*;
(
   input  logic [7:0] op,
   input  logic       qe_en,
   output cmd_desc_t  desc
);
   logic known;

   always_comb begin
      desc          = '0;
      desc.adr_w    = LN1;
      desc.dat_w    = LN1;
      desc.has_adr  = 1'b1;
      known         = 1'b1;
      case (op)
         OP_RD1:   ;
         OP_FRD1:  desc.dummy = 4'd8;
         OP_FRD2O: begin desc.dummy = 4'd8; desc.dat_w = LN2; end
         OP_FRD2A: begin desc.adr_w = LN2; desc.dat_w = LN2; desc.has_mode = 1'b1; end
         OP_FRD4O: begin desc.dummy = 4'd8; desc.dat_w = LN4; desc.quad = 1'b1; end
         OP_FRD4A: begin desc.adr_w = LN4; desc.dat_w = LN4; desc.has_mode = 1'b1;
                         desc.dummy = 4'd4; desc.quad = 1'b1; end
         OP_WRD4:  begin desc.adr_w = LN4; desc.dat_w = LN4; desc.has_mode = 1'b1;
                         desc.dummy = 4'd2; desc.quad = 1'b1; end
         OP_OWRD4: begin desc.adr_w = LN4; desc.dat_w = LN4; desc.has_mode = 1'b1;
                         desc.quad = 1'b1; end
         OP_STR:   begin desc.has_adr = 1'b0; desc.src_stat = 1'b1; end
         OP_STW:   begin desc.has_adr = 1'b0; desc.wr_stat = 1'b1; end
         default:  known = 1'b0;  // R12: unlisted opcodes are refused
      endcase
      // R8: four-lane commands need the quad-enable flag
      desc.ok = known & ~(desc.quad & ~qe_en);
   end
endmodule

// File: rtl/mlane_flash_array.sv
module mlane_flash_array #(
   parameter int unsigned DEPTH   = 256,
   parameter int unsigned PAT_MUL = 37,
   parameter int unsigned PAT_ADD = 11,
   localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       rd
);
   logic [7:0] mem [DEPTH];

   // R10: fixed contents computed per entry
   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      assign mem[i] = 8'((i * PAT_MUL + PAT_ADD) % 256);
   end

   assign rd = mem[idx];
endmodule

// File: rtl/mlane_flash_rd.sv
module mlane_flash_rd
   import mlane_flash_pkg::*;
#(
   parameter int unsigned DEPTH       = 256,
   parameter int unsigned ADDR_BITS   = 24,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          QE_RESET    = 1'b0,
   parameter int unsigned PAT_MUL     = 37,
   parameter int unsigned PAT_ADD     = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sck,
   input  logic       spi_cs_n,
   input  logic [3:0] io_in,
   output logic [3:0] io_out,
   output logic [3:0] io_oe
);
   localparam int unsigned IDX_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(ADDR_BITS + 1);
   localparam logic [CNT_W-1:0] ADR_END  = CNT_W'(ADDR_BITS);
   localparam logic [CNT_W-1:0] MODE_END = CNT_W'(8);
   localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(7);

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("mlane_flash_rd: DEPTH must be a power of two");
   end
   if ((ADDR_BITS % 4 != 0) || (ADDR_BITS < IDX_W) || (ADDR_BITS < 8)) begin : g_bad_abits
      $error("mlane_flash_rd: ADDR_BITS must be a multiple of 4 covering the array");
   end

   logic           cs_n_s, sck_r, sck_f;
   logic [3:0]     io_s;
   phase_e         ph;
   cmd_desc_t      dsc_d, dsc_q;
   logic [6:0]     opc_sr;
   logic [7:0]     op_full;
   logic [CNT_W-1:0] cnt, a_step;
   logic [ADDR_BITS-1:0] adr_q;
   logic           qe_q;
   logic [7:0]     osr, arr_byte, stat_byte, out_src;
   logic [3:0]     left, left_base, d_step;

   mlane_flash_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .io(io_in),
      .cs_n_s(cs_n_s), .io_s(io_s), .sck_rise(sck_r), .sck_fall(sck_f)
   );

   assign op_full = {opc_sr, io_s[0]};

   mlane_flash_decode u_dec (.op(op_full), .qe_en(qe_q), .desc(dsc_d));

   mlane_flash_array #(.DEPTH(DEPTH), .PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD)) u_arr (
      .idx(adr_q[IDX_W-1:0]), .rd(arr_byte)
   );

   function automatic logic [ADDR_BITS-1:0] shift_in(logic [ADDR_BITS-1:0] a,
                                                     lanes_e w, logic [3:0] d);
      case (w)
         LN2:     return {a[ADDR_BITS-3:0], d[1:0]};
         LN4:     return {a[ADDR_BITS-5:0], d};
         default: return {a[ADDR_BITS-2:0], d[0]};
      endcase
   endfunction

   assign a_step    = CNT_W'(lane_bits(dsc_q.adr_w));
   assign d_step    = 4'(lane_bits(dsc_q.dat_w));
   assign stat_byte = {6'b0, qe_q, 1'b0};
   assign left_base = (left == 4'd0) ? 4'd8 : left;

   always_comb begin
      if (left != 4'd0)        out_src = osr;
      else if (dsc_q.src_stat) out_src = stat_byte;
      else                     out_src = arr_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_OPC;
         dsc_q  <= '0;
         opc_sr <= '0;
         cnt    <= '0;
         adr_q  <= '0;
         qe_q   <= QE_RESET;
         osr    <= '0;
         left   <= '0;
         io_out <= '0;
         io_oe  <= '0;
      end else if (cs_n_s) begin
         // R1: deselect aborts and floats all lanes
         ph     <= PH_OPC;
         cnt    <= '0;
         left   <= '0;
         io_out <= '0;
         io_oe  <= '0;
      end else begin
         if (sck_r) begin
            case (ph)
               PH_OPC: begin
                  opc_sr <= op_full[6:0];
                  if (cnt == OPC_LAST) begin
                     cnt   <= '0;
                     dsc_q <= dsc_d;
                     if (!dsc_d.ok)          ph <= PH_IGN;
                     else if (dsc_d.wr_stat) ph <= PH_WST;
                     else if (dsc_d.has_adr) ph <= PH_ADR;
                     else                    ph <= PH_DAT;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PH_ADR: begin
                  adr_q <= shift_in(adr_q, dsc_q.adr_w, io_s);
                  if (cnt + a_step == ADR_END) begin
                     cnt <= '0;
                     if (dsc_q.has_mode)           ph <= PH_MOD;
                     else if (dsc_q.dummy != 4'd0) ph <= PH_DUM;
                     else                          ph <= PH_DAT;
                  end else begin
                     cnt <= cnt + a_step;
                  end
               end
               PH_MOD: begin
                  if (cnt + a_step == MODE_END) begin
                     cnt <= '0;
                     ph  <= (dsc_q.dummy != 4'd0) ? PH_DUM : PH_DAT;
                  end else begin
                     cnt <= cnt + a_step;
                  end
               end
               PH_DUM: begin
                  if (cnt + 1'b1 == CNT_W'(dsc_q.dummy)) begin
                     cnt <= '0;
                     ph  <= PH_DAT;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PH_WST: begin
                  opc_sr <= op_full[6:0];
                  if (cnt == OPC_LAST) begin
                     qe_q <= op_full[1];   // R9
                     cnt  <= '0;
                     ph   <= PH_IGN;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
         if (sck_f && ph == PH_DAT) begin
            io_oe  <= lane_mask(dsc_q.dat_w);
            io_out <= lane_put(out_src, dsc_q.dat_w);
            osr    <= out_src << d_step;
            left   <= left_base - d_step;
            if (left == 4'd0 && !dsc_q.src_stat)
               adr_q[IDX_W-1:0] <= adr_q[IDX_W-1:0] + 1'b1;   // R10
         end
      end
   end

   // R1: lanes float one cycle after a settled deselect
   assert_float_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (io_oe == 4'b0000));

   // R3: enable pattern is always one of the legal lane groups
   assert_lane_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_oe == 4'b0000) || (io_oe == 4'b0010) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

   // R8: upper lanes only driven for an accepted quad command with the flag set
   assert_quad_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      io_oe[3] |-> (qe_q && dsc_q.quad));

   // R2: the bit counter never runs past the address length
   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= ADR_END);

   // R10: every fresh byte advances the array pointer by one, modulo DEPTH
   assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_s && sck_f && ph == PH_DAT && left == 4'd0 && !dsc_q.src_stat)
      |=> (adr_q[IDX_W-1:0] == IDX_W'($past(adr_q[IDX_W-1:0]) + 1'b1)));
endmodule

// File: tb/mlane_flash_rd_tb_top.sv
module mlane_flash_rd_tb_top;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n, sck, cs_n;
   logic [3:0] io_drv;
   logic [3:0] io_out, io_oe;
   int total = 0, bad = 0;
   logic [7:0] rx [8];
   int oe_bad;

   mlane_flash_rd dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
      .io_in(io_drv), .io_out(io_out), .io_oe(io_oe)
   );

   typedef struct packed {
      logic        m3;
      logic [7:0]  op;
      logic [23:0] adr;
      logic [3:0]  n;
      logic [3:0]  req;
   } vec_t;

   // walked by one loop; quad entries run with the flag set
   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'h03, 24'h000010, 4'd3, 4'd3},   // R3 plain read
      '{1'b1, 8'h03, 24'h000020, 4'd2, 4'd11},  // R11 mode 3
      '{1'b0, 8'h0B, 24'h0000F0, 4'd2, 4'd3},   // R3 fast read
      '{1'b0, 8'h3B, 24'h000041, 4'd3, 4'd4},   // R4
      '{1'b0, 8'hBB, 24'h00007E, 4'd3, 4'd5},   // R5
      '{1'b1, 8'hBB, 24'h001234, 4'd2, 4'd2},   // R2 high bits dropped
      '{1'b0, 8'h6B, 24'h000005, 4'd2, 4'd6},   // R6
      '{1'b1, 8'hEB, 24'h0000A0, 4'd3, 4'd7},   // R7
      '{1'b0, 8'hE7, 24'h0000C3, 4'd2, 4'd7},   // R7
      '{1'b0, 8'hE3, 24'h0000FE, 4'd3, 4'd10}   // R10 wrap
   };

   function automatic logic [7:0] pat(int a);
      return 8'((((a % 256) * 37) + 11) % 256);
   endfunction

   function automatic logic [3:0] exp_mask(int w);
      return (w == 1) ? 4'b0010 : (w == 2) ? 4'b0011 : 4'b1111;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input logic [3:0] din, output logic [3:0] dout,
                       output logic [3:0] doe);
      @(negedge clk); sck = 1'b0; io_drv = din;
      repeat (6) @(negedge clk);
      dout = io_out; doe = io_oe; sck = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic begin_x(input bit m3);
      @(negedge clk); sck = m3;
      repeat (3) @(negedge clk); cs_n = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic end_x(input bit m3);
      @(negedge clk); sck = m3;
      repeat (3) @(negedge clk); cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic send_bits(input logic [31:0] val, input int nbits, input int w);
      logic [3:0] o, e;
      for (int i = nbits - w; i >= 0; i -= w)
         tick(4'(val >> i) & 4'((1 << w) - 1), o, e);
   endtask

   task automatic idle_ticks(input int n);
      logic [3:0] o, e;
      for (int i = 0; i < n; i++) begin
         tick(4'b0000, o, e);
         if (e != 4'b0000) oe_bad++;
      end
   endtask

   task automatic get_bytes(input int n, input int w);
      logic [3:0] o, e;
      logic [7:0] v;
      for (int b = 0; b < n; b++) begin
         v = '0;
         for (int k = 0; k < 8 / w; k++) begin
            tick(4'b0000, o, e);
            if (e != exp_mask(w)) oe_bad++;
            v = (w == 1) ? {v[6:0], o[1]} : 8'((v << w) | (o & 4'((1 << w) - 1)));
         end
         rx[b] = v;
      end
   endtask

   task automatic bdesc(input logic [7:0] op, output int aw, output int md,
                        output int dm, output int dw);
      aw = 1; md = 0; dm = 0; dw = 1;
      case (op)
         8'h0B: dm = 8;
         8'h3B: begin dm = 8; dw = 2; end
         8'hBB: begin aw = 2; md = 8; dw = 2; end
         8'h6B: begin dm = 8; dw = 4; end
         8'hEB: begin aw = 4; md = 8; dm = 4; dw = 4; end
         8'hE7: begin aw = 4; md = 8; dm = 2; dw = 4; end
         8'hE3: begin aw = 4; md = 8; dw = 4; end
         default: ;
      endcase
   endtask

   task automatic read_cmd(input bit m3, input logic [7:0] op,
                           input logic [23:0] a, input int n);
      int aw, md, dm, dw;
      bdesc(op, aw, md, dm, dw);
      oe_bad = 0;
      begin_x(m3);
      send_bits({24'b0, op}, 8, 1);
      send_bits({8'b0, a}, 24, aw);
      if (md != 0) send_bits(32'h0, 8, aw);
      if (dm != 0) idle_ticks(dm);
      get_bytes(n, dw);
      end_x(m3);
   endtask

   task automatic status_read(output logic [7:0] s);
      oe_bad = 0;
      begin_x(1'b0);
      send_bits(32'h35, 8, 1);
      get_bytes(1, 1);
      end_x(1'b0);
      s = rx[0];
   endtask

   task automatic status_write(input logic [7:0] v);
      begin_x(1'b0);
      send_bits(32'h31, 8, 1);
      send_bits({24'b0, v}, 8, 1);
      end_x(1'b0);
   endtask

   task automatic ignored_cmd(input logic [7:0] op, input int n);
      oe_bad = 0;
      begin_x(1'b0);
      send_bits({24'b0, op}, 8, 1);
      idle_ticks(n);
      end_x(1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] s;
      logic [3:0] o, e;
      rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; io_drv = 4'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(io_oe == 4'b0000, "R1", "reset lanes", io_oe, 0);

      // R9: flag resets to 0
      status_read(s);
      chk(s == 8'h00, "R9", "status after reset", s, 8'h00);

      // R8: quad read refused while flag is clear
      ignored_cmd(8'h6B, 48);
      chk(oe_bad == 0, "R8", "6Bh with flag clear", oe_bad, 0);

      // R12: unknown opcode
      ignored_cmd(8'h9F, 40);
      chk(oe_bad == 0, "R12", "unknown opcode", oe_bad, 0);

      // R9: only bit 1 is stored
      status_write(8'hFF);
      status_read(s);
      chk(s == 8'h02, "R9", "status after set", s, 8'h02);

      for (int v = 0; v < NV; v++) begin
         read_cmd(VECS[v].m3, VECS[v].op, VECS[v].adr, int'(VECS[v].n));
         for (int b = 0; b < int'(VECS[v].n); b++)
            chk(rx[b] == pat(int'(VECS[v].adr[7:0]) + b),
                $sformatf("R%0d", VECS[v].req),
                $sformatf("op %h byte %0d", VECS[v].op, b),
                rx[b], pat(int'(VECS[v].adr[7:0]) + b));
         chk(oe_bad == 0, $sformatf("R%0d", VECS[v].req),
             $sformatf("op %h lane enables", VECS[v].op), oe_bad, 0);
      end

      // R10: single-lane wrap at the top of the array
      read_cmd(1'b0, 8'h0B, 24'h0000FF, 2);
      chk(rx[0] == pat(255), "R10", "byte at 0xFF", rx[0], pat(255));
      chk(rx[1] == pat(0), "R10", "wrapped byte", rx[1], pat(0));

      // R1: abort halfway through a data byte
      begin_x(1'b0);
      send_bits(32'h03, 8, 1);
      send_bits(32'h000010, 24, 1);
      for (int k = 0; k < 4; k++) tick(4'b0000, o, e);
      end_x(1'b0);
      chk(io_oe == 4'b0000, "R1", "lanes after abort", io_oe, 0);
      read_cmd(1'b0, 8'h03, 24'h000050, 1);
      chk(rx[0] == pat(8'h50), "R1", "command after abort", rx[0], pat(8'h50));

      // R9 / R8: clearing the flag refuses quad again
      status_write(8'h00);
      status_read(s);
      chk(s == 8'h00, "R9", "status after clear", s, 8'h00);
      ignored_cmd(8'hEB, 40);
      chk(oe_bad == 0, "R8", "EBh with flag clear", oe_bad, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule